// File: doc/BRIEF.md
# Dual-Context Speculation Control Register

This block keeps one speculation-control register in two copies, one owned by the host and one owned by a guest. A mode flag selects which copy software reaches. While the host runs, only the host copy is live. While a guest runs, the control value sent to the speculation logic is the union of both copies. The host can therefore hold certain bits set whatever the guest writes.

When the core enters a guest, the block fetches the guest copy from a 32-bit slot in a memory save area, at byte offset 0x2E0 from a base address given with the event. When the core leaves the guest, the block writes the guest copy back to the same slot. Both transfers use a single request/acknowledge port. The mode flag changes only when the acknowledge arrives. A busy output marks the whole transfer. A register write that arrives during a transfer is held in a one-entry slot and applied once the transfer ends. A constant feature word advertises that the block is present.

Top module: `spec_ctx_top`

## Requirements
- R1: After reset both copies are zero. The block is in host mode (`in_guest`=0), with `busy`=0, `mem_req`=0, `rd_data`=0 and `eff_ctrl`=0.
- R2: In host mode, with the block not busy, a write changes only the host copy. From the next cycle `rd_data` and `eff_ctrl` both equal the written value.
- R3: A guest-entry event accepted in host mode raises `mem_req` in the next cycle, with `mem_we`=0 and `mem_addr` = `save_base` + 0x2E0. In the cycle after `mem_ack`, the guest copy holds `mem_rdata` and `in_guest`=1. The mode never changes except in the cycle after an acknowledged request.
- R4: In guest mode, writes change only the guest copy. The host copy, seen through `eff_ctrl` after the next exit, is unchanged.
- R5: In guest mode, `eff_ctrl` equals the guest copy ORed with the host copy.
- R6: A guest-exit event accepted in guest mode raises `mem_req` in the next cycle, with `mem_we`=1, `mem_addr` = `save_base` + 0x2E0 and `mem_wdata` = the guest copy. In the cycle after `mem_ack`, `in_guest`=0 and `eff_ctrl` equals the host copy.
- R7: `busy` and `mem_req` are high from the cycle after an accepted event up to and including the acknowledge cycle. While waiting for the acknowledge, the address, direction and write data do not change.
- R8: A write that arrives while busy does not change `rd_data` during the transfer. It is applied to the copy of the mode that holds after the transfer, in the cycle after the transfer ends.
- R9: An entry event in guest mode, an exit event in host mode, and any event while busy are ignored: no request is made and the mode does not change.
- R10: `feat_word` has bit 20 set and every other bit clear.
- R11: `rd_data` returns the guest copy in guest mode and the host copy in host mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Copy belonging to the current mode |
| enter_evt | input | 1 | Guest-entry event |
| exit_evt | input | 1 | Guest-exit event |
| save_base | input | ADDR_W | Save-area base address, sampled with an event |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = store guest copy, 0 = load it |
| mem_addr | output | ADDR_W | Slot address |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Load data, valid with `mem_ack` |
| eff_ctrl | output | 32 | Effective control value |
| in_guest | output | 1 | Current mode, 1 = guest |
| busy | output | 1 | Transfer in flight |
| feat_word | output | 32 | Capability word |

## Verification
The properties assume that `mem_ack` comes only while `mem_req` is high and lasts a single cycle, and that `enter_evt` and `exit_evt` are never raised together. The bench's memory responder acknowledges exactly once, after a random wait, and raises each event alone, so every run stays inside these assumptions. The checks on the load address also assume that `save_base` is held steady in the cycle the event is sampled. The bench drives the base together with the event.

// File: rtl/spec_ctx_pkg.sv
package spec_ctx_pkg;

    localparam int unsigned CTRL_W         = 32;
    localparam int unsigned FEAT_W         = 32;
    localparam int unsigned CAP_BIT        = 20;
    localparam int unsigned GUEST_SLOT_OFS = 32'h2E0;

    typedef logic [CTRL_W-1:0] ctrl_t;

    typedef enum logic {
        MODE_HOST  = 1'b0,
        MODE_GUEST = 1'b1
    } ctx_mode_e;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_LOAD  = 2'd1,
        XF_STORE = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic  valid;
        ctrl_t data;
    } wr_slot_t;

    function automatic logic [FEAT_W-1:0] feat_word_f();
        logic [FEAT_W-1:0] w;
        w = '0;
        w[CAP_BIT] = 1'b1;
        return w;
    endfunction

    function automatic ctrl_t merge_ctrl(ctx_mode_e m, ctrl_t host, ctrl_t guest);
        return (m == MODE_GUEST) ? (host | guest) : host;
    endfunction

endpackage

// File: rtl/spec_ctx_xfer.sv
module spec_ctx_xfer
    import spec_ctx_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enter_evt,
    input  logic              exit_evt,
    input  logic [ADDR_W-1:0] save_base,
    input  ctrl_t             guest_copy,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output ctrl_t             mem_wdata,
    output ctx_mode_e         mode,
    output logic              load_done,
    output logic              busy
);

    localparam logic [ADDR_W-1:0] SLOT_OFS = ADDR_W'(GUEST_SLOT_OFS);

    xfer_state_e       state_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XF_IDLE;
            addr_q  <= '0;
            mode    <= MODE_HOST;
        end else begin
            unique case (state_q)
                XF_IDLE: begin
                    if (enter_evt && mode == MODE_HOST) begin
                        state_q <= XF_LOAD;
                        addr_q  <= save_base + SLOT_OFS;
                    end else if (exit_evt && mode == MODE_GUEST) begin
                        state_q <= XF_STORE;
                        addr_q  <= save_base + SLOT_OFS;
                    end
                end
                XF_LOAD: begin
                    if (mem_ack) begin
                        state_q <= XF_IDLE;
                        mode    <= MODE_GUEST;
                    end
                end
                XF_STORE: begin
                    if (mem_ack) begin
                        state_q <= XF_IDLE;
                        mode    <= MODE_HOST;
                    end
                end
                default: state_q <= XF_IDLE;
            endcase
        end
    end

    // guest copy cannot move during a store: writes are deferred while busy
    always_comb begin
        busy      = (state_q != XF_IDLE);
        mem_req   = busy;
        mem_we    = (state_q == XF_STORE);
        mem_addr  = addr_q;
        mem_wdata = guest_copy;
        load_done = (state_q == XF_LOAD) && mem_ack;
    end

endmodule

// File: rtl/spec_ctx_regs.sv
module spec_ctx_regs
    import spec_ctx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctx_mode_e mode,
    input  logic      busy,
    input  logic      wr_en,
    input  ctrl_t     wr_data,
    input  logic      load_done,
    input  ctrl_t     load_data,
    output ctrl_t     host_q,
    output ctrl_t     guest_q,
    output ctrl_t     rd_data
);

    wr_slot_t slot_q;
    wr_slot_t apply;

    // a fresh write overrides an older deferred one: both target the same copy
    always_comb begin
        if (wr_en)
            apply = '{valid: 1'b1, data: wr_data};
        else
            apply = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_q  <= '0;
            guest_q <= '0;
            slot_q  <= '0;
        end else begin
            if (load_done)
                guest_q <= load_data;
            if (busy) begin
                if (wr_en)
                    slot_q <= '{valid: 1'b1, data: wr_data};
            end else begin
                slot_q.valid <= 1'b0;
                if (apply.valid) begin
                    if (mode == MODE_GUEST)
                        guest_q <= apply.data;
                    else
                        host_q  <= apply.data;
                end
            end
        end
    end

    always_comb rd_data = (mode == MODE_GUEST) ? guest_q : host_q;

endmodule

// File: rtl/spec_ctx_merge.sv
module spec_ctx_merge
    import spec_ctx_pkg::*;
(
    input  ctx_mode_e          mode,
    input  ctrl_t              host_q,
    input  ctrl_t              guest_q,
    output ctrl_t              eff_ctrl,
    output logic [FEAT_W-1:0]  feat_word
);

    always_comb begin
        eff_ctrl  = merge_ctrl(mode, host_q, guest_q);
        feat_word = feat_word_f();
    end

endmodule

// File: rtl/spec_ctx_top.sv
module spec_ctx_top
    import spec_ctx_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic              enter_evt,
    input  logic              exit_evt,
    input  logic [ADDR_W-1:0] save_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic [31:0]       eff_ctrl,
    output logic              in_guest,
    output logic              busy,
    output logic [31:0]       feat_word
);

    ctx_mode_e mode;
    ctrl_t     host_q;
    ctrl_t     guest_q;
    logic      load_done;

    spec_ctx_xfer #(.ADDR_W(ADDR_W)) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .enter_evt  (enter_evt),
        .exit_evt   (exit_evt),
        .save_base  (save_base),
        .guest_copy (guest_q),
        .mem_ack    (mem_ack),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mode       (mode),
        .load_done  (load_done),
        .busy       (busy)
    );

    spec_ctx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .busy      (busy),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .load_done (load_done),
        .load_data (mem_rdata),
        .host_q    (host_q),
        .guest_q   (guest_q),
        .rd_data   (rd_data)
    );

    spec_ctx_merge u_merge (
        .mode      (mode),
        .host_q    (host_q),
        .guest_q   (guest_q),
        .eff_ctrl  (eff_ctrl),
        .feat_word (feat_word)
    );

    assign in_guest = (mode == MODE_GUEST);

endmodule

// File: rtl/spec_ctx_chk.sv
module spec_ctx_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [31:0]       wr_data,
    input logic [31:0]       rd_data,
    input logic              enter_evt,
    input logic              exit_evt,
    input logic [ADDR_W-1:0] save_base,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack,
    input logic [31:0]       mem_rdata,
    input logic [31:0]       eff_ctrl,
    input logic              in_guest,
    input logic              busy,
    input logic [31:0]       feat_word
);

    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(32'h2E0);

    p_host_write_r2: assert property (@(posedge clk) disable iff (rst)
        (!in_guest && !busy && wr_en) |=> (rd_data == $past(wr_data)));

    p_mode_on_ack_r3: assert property (@(posedge clk) disable iff (rst)
        (in_guest != $past(in_guest)) |-> $past(mem_req && mem_ack));

    p_slot_addr_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> (mem_addr == $past(save_base) + OFS));

    p_guest_union_r5: assert property (@(posedge clk) disable iff (rst)
        in_guest |-> ((eff_ctrl & rd_data) == rd_data));

    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    p_defer_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ack) |=> $stable(rd_data));

    p_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && in_guest && enter_evt && !exit_evt) |=> (!busy && in_guest));

endmodule

bind spec_ctx_top spec_ctx_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/spec_ctx_top_test.sv
module spec_ctx_top_test;

    localparam int AW = 32;
    localparam logic [31:0] OFS = 32'h2E0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic          enter_evt = 1'b0;
    logic          exit_evt = 1'b0;
    logic [AW-1:0] save_base = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic [31:0]   eff_ctrl;
    logic          in_guest, busy;
    logic [31:0]   feat_word;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] host_m = '0;
    logic [31:0] guest_m = '0;
    logic        mode_m = 1'b0;
    logic [31:0] saved_m = '0;

    spec_ctx_top #(.ADDR_W(AW)) uut (.*);

    always #5 clk = ~clk;

    function automatic logic [31:0] exp_eff();
        return mode_m ? (host_m | guest_m) : host_m;
    endfunction

    function automatic logic [31:0] exp_rd();
        return mode_m ? guest_m : host_m;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check_state(string tag);
        chk({tag, " R11 rd_data"}, rd_data, exp_rd());
        chk(mode_m ? {tag, " R5 eff"} : {tag, " R2 eff"}, eff_ctrl, exp_eff());
        chk({tag, " mode"}, in_guest, mode_m);
        chk({tag, " R7 idle busy"}, busy, 1'b0);
    endtask

    task automatic write_op(logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0;
        if (mode_m) guest_m = d; else host_m = d;
        check_state(mode_m ? "R4 guest write" : "R2 host write");
    endtask

    task automatic transfer(bit entering, logic [AW-1:0] base, logic [31:0] val,
                            int lat, bit pend, logic [31:0] pd);
        logic [31:0] rd_before;
        if (entering) enter_evt = 1'b1; else exit_evt = 1'b1;
        save_base = base;
        step();
        enter_evt = 1'b0; exit_evt = 1'b0;
        rd_before = rd_data;
        chk("R7 busy after event", {busy, mem_req}, 2'b11);
        chk(entering ? "R3 load dir" : "R6 store dir", mem_we, !entering);
        chk(entering ? "R3 slot addr" : "R6 slot addr", mem_addr, base + OFS);
        if (!entering) chk("R6 store data", mem_wdata, guest_m);
        for (int i = 0; i < lat; i++) begin
            if (pend && i == 0) begin
                wr_en = 1'b1; wr_data = pd;
            end
            step();
            wr_en = 1'b0;
            chk("R7 req held", {mem_req, busy}, 2'b11);
            chk("R7 addr held", mem_addr, base + OFS);
            chk("R8 deferred write not visible", rd_data, rd_before);
        end
        mem_ack = 1'b1; mem_rdata = val;
        step();
        mem_ack = 1'b0;
        if (entering) begin
            guest_m = val; mode_m = 1'b1;
        end else begin
            saved_m = guest_m; mode_m = 1'b0;
        end
        chk(entering ? "R3 in guest after ack" : "R6 in host after ack", in_guest, mode_m);
        step();
        if (pend && lat > 0) begin
            if (mode_m) guest_m = pd; else host_m = pd;
        end
        check_state(entering ? "R3 after entry" : "R6 after exit");
    endtask

    task automatic ignored_evt();
        if (mode_m) enter_evt = 1'b1; else exit_evt = 1'b1;
        step();
        enter_evt = 1'b0; exit_evt = 1'b0;
        chk("R9 ignored event no request", {busy, mem_req}, 2'b00);
        chk("R9 ignored event mode", in_guest, mode_m);
        step();
        check_state("R9 after ignored event");
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errs++; checks++;
                $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
                $display("Result: errors=%0d of %0d checks", errs, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd7741));
        step(); step();
        rst = 1'b0;
        step();
        chk("R1 reset rd_data", rd_data, 32'h0);
        chk("R1 reset eff", eff_ctrl, 32'h0);
        chk("R1 reset mode/busy/req", {in_guest, busy, mem_req}, 3'b000);
        chk("R10 feature word", feat_word, 32'h0010_0000);

        // directed corners
        write_op(32'h0000_0005);                                   // R2
        transfer(1, 32'h1000_0000, 32'h0000_0002, 0, 0, 0);        // R3 immediate ack
        chk("R5 union", eff_ctrl, 32'h0000_0007);
        write_op(32'h0000_0000);                                   // R4 guest clears own bits
        chk("R5 host floor kept", eff_ctrl, 32'h0000_0005);
        ignored_evt();                                             // R9 enter in guest
        transfer(0, 32'h1000_0000, 32'h0, 3, 1, 32'h0000_0018);    // R6 + R8 into host
        chk("R4 host copy after guest writes", eff_ctrl, 32'h0000_0018);
        ignored_evt();                                             // R9 exit in host
        transfer(1, 32'h2000_0040, 32'hA5A5_0001, 2, 1, 32'h0000_00F0); // R8 into guest
        chk("R8 deferred write hits guest", rd_data, 32'h0000_00F0);
        transfer(0, 32'h2000_0040, 32'h0, 1, 0, 0);
        chk("R6 stored value", saved_m, 32'h0000_00F0);

        // constrained random
        for (int it = 0; it < 300; it++) begin
            int op = $urandom_range(0, 9);
            int lat = $urandom_range(0, 4);
            logic [31:0] d = $urandom;
            logic [AW-1:0] b = {$urandom} & 32'hFFFF_F000;
            if (op < 5) write_op(d);
            else if (op < 8) transfer(!mode_m, b, (op == 5) ? saved_m : $urandom,
                                      lat, $urandom_range(0, 1), $urandom);
            else ignored_evt();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule